// File: doc/BRIEF.md
# Digital Downconverter Channel

This block is one tunable narrowband channel for a wideband digitizer. It takes a stream of real samples. A numerically controlled oscillator drives a quadrature mixer that moves a selected frequency to baseband. The in-phase and quadrature rails then pass through a lowpass FIR filter whose coefficients software can load. The filter output is kept only once every D input samples, so the FIR works as an anti-alias filter placed directly in front of an integer decimator. A final stage applies gain and offset to each rail on its own and saturates the result to the output width.

All inputs are plain wires. This lets several copies share the same input sample stream, each with its own tuning word, decimation factor, coefficients and correction values. The output is a decimated I/Q stream. `out_valid` pulses for one cycle per output pair, and the output values hold between pulses.

Top module: `ddc_channel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_i` and `out_q` are 0. Reset also clears the oscillator phase, the filter history, the decimation count and all coefficients to 0.
- R2: The oscillator keeps a 32-bit phase that starts at 0 and advances by `tune_word` on every accepted input sample. Sample n uses the phase held before that advance. Bits 31:24 of the phase select entry k of a 256-entry table, where cos[k] = floor(2047*cos(2*pi*k/256)+0.5) and sin[k] is formed the same way with sine.
- R3: For each input sample x, the mixer output is m_i = (x*cos[k]) >>> 11 and m_q = (-(x*sin[k])) >>> 11. The shift is arithmetic and rounds toward minus infinity.
- R4: At an output instant, the filter value on each rail is (sum over t=0..7 of c[t]*m[n-t]) >>> 15. Here m[n] is the newest mixer value, and history entries before reset are taken as 0.
- R5: With D = `dec_factor` (a value of 0 is treated as 1), exactly one output is produced for every D input samples. Outputs fall on inputs D-1, 2D-1 and so on, counted from 0 after reset. Each output comes out in input order as a single-cycle `out_valid` pulse.
- R6: When `coef_we` is high, `coef_data` is written to tap `coef_addr`. Tap 0 weights the newest sample. The new value takes effect from the next output and leaves earlier outputs unchanged.
- R7: Each rail is corrected separately: out = ((f*gain) >>> 12) + offset. The gain is a signed value with 12 fraction bits, so 4096 means unity, and `gain_i`/`offset_i` act on I only while `gain_q`/`offset_q` act on Q only.
- R8: A corrected value above 32767 becomes 32767, and a value below -32768 becomes -32768. The output never wraps.
- R9: Between `out_valid` pulses, `out_i` and `out_q` keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 12 | Signed real input sample |
| tune_word | input | 32 | Phase increment per sample |
| dec_factor | input | 8 | Decimation factor D (0 acts as 1) |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 3 | Tap index to write |
| coef_data | input | 16 | Signed coefficient, 15 fraction bits |
| gain_i | input | 16 | Signed I gain, 12 fraction bits |
| gain_q | input | 16 | Signed Q gain, 12 fraction bits |
| offset_i | input | 16 | Signed I offset |
| offset_q | input | 16 | Signed Q offset |
| out_valid | output | 1 | Output pair strobe |
| out_i | output | 16 | Corrected in-phase output |
| out_q | output | 16 | Corrected quadrature output |

## Verification
The hardest case to reach is a coefficient rewrite that lands between two outputs while the history and the decimation count carry over. The stimulus drains the pipeline without a reset, rewrites the taps and then resumes the stream. The bench model then expects the old taps on every output before the write and the new taps after it. Saturation on both rails is driven on purpose, using large gains combined with offsets of opposite sign. Random tuning words and gapped valid patterns cover the phase wrap and the decimation count at several values of D, including D=0 and D=1.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  // Rounded table entry: amp*cos or amp*sin of 2*pi*k/depth
  function automatic int lut_val(input int k, input int amp, input int depth, input bit use_sin);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(k) / real'(depth);
    v = use_sin ? $sin(ang) : $cos(ang);
    return $rtoi($floor(real'(amp) * v + 0.5));
  endfunction
endpackage

// File: rtl/ddc_nco_mixer.sv
module ddc_nco_mixer #(
  parameter int SAMPLE_W = 12,
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 8,
  parameter int LUT_W    = 12,
  parameter int MIX_W    = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  input  logic [PHASE_W-1:0]         tune_word,
  output logic                       mix_v,
  output logic signed [MIX_W-1:0]    mix_i,
  output logic signed [MIX_W-1:0]    mix_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP   = (1 << (LUT_W - 1)) - 1;

  logic signed [LUT_W-1:0] rom_c [DEPTH];
  logic signed [LUT_W-1:0] rom_s [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      rom_c[k] = LUT_W'(ddc_pkg::lut_val(k, AMP, DEPTH, 1'b0));
      rom_s[k] = LUT_W'(ddc_pkg::lut_val(k, AMP, DEPTH, 1'b1));
    end
  end

  logic [PHASE_W-1:0]         phase;
  logic [ADDR_W-1:0]          addr;
  logic signed [LUT_W-1:0]    cos_q, sin_q;
  logic signed [SAMPLE_W-1:0] samp_q;
  logic                       v_q;
  logic signed [47:0]         prod_i, prod_q;

  assign addr = phase[PHASE_W-1 -: ADDR_W];

  // table read kept free of reset so it maps to block RAM
  always_ff @(posedge clk) begin
    cos_q  <= rom_c[addr];
    sin_q  <= rom_s[addr];
    samp_q <= in_sample;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      v_q   <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) phase <= phase + tune_word;
    end
  end

  assign prod_i = samp_q * cos_q;
  assign prod_q = -(samp_q * sin_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mix_v <= 1'b0;
      mix_i <= '0;
      mix_q <= '0;
    end else begin
      mix_v <= v_q;
      if (v_q) begin
        mix_i <= MIX_W'(prod_i >>> (LUT_W - 1));
        mix_q <= MIX_W'(prod_q >>> (LUT_W - 1));
      end
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase)); // R2
  AST_MIX_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    mix_v |-> $past(in_valid, 2)); // R3
endmodule

// File: rtl/ddc_fir_decim.sv
module ddc_fir_decim #(
  parameter int MIX_W  = 13,
  parameter int COEF_W = 16,
  parameter int TAPS   = 8,
  parameter int DEC_W  = 8,
  parameter int FIR_W  = 17
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mix_v,
  input  logic signed [MIX_W-1:0]   mix_i,
  input  logic signed [MIX_W-1:0]   mix_q,
  input  logic [DEC_W-1:0]          dec_factor,
  input  logic                      coef_we,
  input  logic [$clog2(TAPS)-1:0]   coef_addr,
  input  logic signed [COEF_W-1:0]  coef_data,
  output logic                      fir_v,
  output logic signed [FIR_W-1:0]   fir_i,
  output logic signed [FIR_W-1:0]   fir_q
);
  logic [TAPS-1:0][COEF_W-1:0] coef_q;
  logic [TAPS-1:0][MIX_W-1:0]  hist_i, hist_q;
  logic [DEC_W-1:0]            cnt_q, dec_eff;
  logic                        fire_q;
  logic signed [47:0]          acc_i, acc_q;

  assign dec_eff = (dec_factor == '0) ? DEC_W'(1) : dec_factor;

  always_ff @(posedge clk) begin
    if (rst) coef_q <= '0;
    else if (coef_we) coef_q[coef_addr] <= coef_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_i <= '0;
      hist_q <= '0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (mix_v) begin
        hist_i <= {hist_i[TAPS-2:0], mix_i};
        hist_q <= {hist_q[TAPS-2:0], mix_q};
        if (cnt_q >= dec_eff - DEC_W'(1)) begin
          cnt_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + DEC_W'(1);
        end
      end
    end
  end

  // dot product evaluated only at output instants
  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int t = 0; t < TAPS; t++) begin
      acc_i = acc_i + $signed(coef_q[t]) * $signed(hist_i[t]);
      acc_q = acc_q + $signed(coef_q[t]) * $signed(hist_q[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fir_v <= 1'b0;
      fir_i <= '0;
      fir_q <= '0;
    end else begin
      fir_v <= fire_q;
      if (fire_q) begin
        fir_i <= FIR_W'(acc_i >>> (COEF_W - 1));
        fir_q <= FIR_W'(acc_q >>> (COEF_W - 1));
      end
    end
  end

  AST_FIRE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> $past(mix_v)); // R5
  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !coef_we |=> $stable(coef_q)); // R6
endmodule

// File: rtl/ddc_gain_offset.sv
module ddc_gain_offset #(
  parameter int FIR_W     = 17,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 12,
  parameter int OUT_W     = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fir_v,
  input  logic signed [FIR_W-1:0]  fir_i,
  input  logic signed [FIR_W-1:0]  fir_q,
  input  logic signed [GAIN_W-1:0] gain_i,
  input  logic signed [GAIN_W-1:0] gain_q,
  input  logic signed [OUT_W-1:0]  offset_i,
  input  logic signed [OUT_W-1:0]  offset_q,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);
  localparam logic signed [47:0] MAXV = (48'sd1 <<< (OUT_W - 1)) - 48'sd1;
  localparam logic signed [47:0] MINV = -(48'sd1 <<< (OUT_W - 1));

  logic signed [47:0] raw_i, raw_q;

  assign raw_i = ((fir_i * gain_i) >>> GAIN_FRAC) + offset_i;
  assign raw_q = ((fir_q * gain_q) >>> GAIN_FRAC) + offset_q;

  function automatic logic signed [OUT_W-1:0] clip(input logic signed [47:0] v);
    if (v > MAXV) return MAXV[OUT_W-1:0];
    if (v < MINV) return MINV[OUT_W-1:0];
    return v[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= fir_v;
      if (fir_v) begin
        out_i <= clip(raw_i);
        out_q <= clip(raw_q);
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fir_v |=> (!out_valid && $stable(out_i) && $stable(out_q))); // R9
  AST_PULSE_FROM_FILTER: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(fir_v)); // R5
endmodule

// File: rtl/ddc_channel.sv
module ddc_channel #(
  parameter int SAMPLE_W  = 12,
  parameter int PHASE_W   = 32,
  parameter int LUT_ADDR  = 8,
  parameter int LUT_W     = 12,
  parameter int COEF_W    = 16,
  parameter int TAPS      = 8,
  parameter int DEC_W     = 8,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 12,
  parameter int OUT_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [SAMPLE_W-1:0]       in_sample,
  input  logic [PHASE_W-1:0]        tune_word,
  input  logic [DEC_W-1:0]          dec_factor,
  input  logic                      coef_we,
  input  logic [$clog2(TAPS)-1:0]   coef_addr,
  input  logic [COEF_W-1:0]         coef_data,
  input  logic [GAIN_W-1:0]         gain_i,
  input  logic [GAIN_W-1:0]         gain_q,
  input  logic [OUT_W-1:0]          offset_i,
  input  logic [OUT_W-1:0]          offset_q,
  output logic                      out_valid,
  output logic [OUT_W-1:0]          out_i,
  output logic [OUT_W-1:0]          out_q
);
  localparam int MIX_W = SAMPLE_W + 1;
  localparam int FIR_W = MIX_W + $clog2(TAPS) + 1;

  logic                     mix_v, fir_v;
  logic signed [MIX_W-1:0]  mix_i, mix_q;
  logic signed [FIR_W-1:0]  fir_i, fir_q;
  logic signed [OUT_W-1:0]  res_i, res_q;

  ddc_nco_mixer #(.SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W), .ADDR_W(LUT_ADDR),
                  .LUT_W(LUT_W), .MIX_W(MIX_W)) u_mix (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample($signed(in_sample)),
    .tune_word(tune_word), .mix_v(mix_v), .mix_i(mix_i), .mix_q(mix_q));

  ddc_fir_decim #(.MIX_W(MIX_W), .COEF_W(COEF_W), .TAPS(TAPS), .DEC_W(DEC_W),
                  .FIR_W(FIR_W)) u_fir (
    .clk(clk), .rst(rst), .mix_v(mix_v), .mix_i(mix_i), .mix_q(mix_q),
    .dec_factor(dec_factor), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data($signed(coef_data)), .fir_v(fir_v), .fir_i(fir_i), .fir_q(fir_q));

  ddc_gain_offset #(.FIR_W(FIR_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
                    .OUT_W(OUT_W)) u_corr (
    .clk(clk), .rst(rst), .fir_v(fir_v), .fir_i(fir_i), .fir_q(fir_q),
    .gain_i($signed(gain_i)), .gain_q($signed(gain_q)),
    .offset_i($signed(offset_i)), .offset_q($signed(offset_q)),
    .out_valid(out_valid), .out_i(res_i), .out_q(res_q));

  assign out_i = res_i;
  assign out_q = res_q;
endmodule

// File: tb/ddc_channel_test.sv
module ddc_channel_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic [31:0] tune_word = '0;
  logic [7:0]  dec_factor = 8'd1;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic [15:0] gain_i = 16'd4096, gain_q = 16'd4096, offset_i = '0, offset_q = '0;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  int checks = 0, failures = 0, cycles = 0, sat_seen = 0;
  bit done = 0;

  ddc_channel uut (.*);

  always #5 clk = ~clk;

  // bench model state
  logic [31:0] m_phase;
  longint m_hi[8], m_hq[8], m_coef[8];
  int m_cnt;
  longint exp_i[$], exp_q[$];
  string cur_req = "R4";

  function automatic longint tab(input int k, input bit s);
    real a;
    a = 2.0 * 3.14159265358979 * real'(k) / 256.0;
    return longint'($rtoi($floor(2047.0 * (s ? $sin(a) : $cos(a)) + 0.5)));
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint sx16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic model_reset();
    m_phase = '0; m_cnt = 0;
    for (int t = 0; t < 8; t++) begin m_hi[t] = 0; m_hq[t] = 0; m_coef[t] = 0; end
    exp_i.delete(); exp_q.delete();
  endtask

  task automatic model_step(input longint x);
    int k, d;
    longint si, sq, yi, yq;
    k = int'(m_phase[31:24]);
    for (int t = 7; t > 0; t--) begin m_hi[t] = m_hi[t-1]; m_hq[t] = m_hq[t-1]; end
    m_hi[0] = (x * tab(k, 0)) >>> 11;
    m_hq[0] = (-(x * tab(k, 1))) >>> 11;
    m_phase = m_phase + tune_word;
    d = (dec_factor == 0) ? 1 : int'(dec_factor);
    if (m_cnt >= d - 1) begin
      m_cnt = 0;
      si = 0; sq = 0;
      for (int t = 0; t < 8; t++) begin si += m_coef[t] * m_hi[t]; sq += m_coef[t] * m_hq[t]; end
      si = si >>> 15; sq = sq >>> 15;
      yi = ((si * sx16(gain_i)) >>> 12) + sx16(offset_i);
      yq = ((sq * sx16(gain_q)) >>> 12) + sx16(offset_q);
      if (yi != sat16(yi) || yq != sat16(yq)) sat_seen++;
      exp_i.push_back(sat16(yi));
      exp_q.push_back(sat16(yq));
    end else m_cnt++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  task automatic write_coef(input int a, input int v);
    @(negedge clk); coef_we = 1'b1; coef_addr = 3'(a); coef_data = 16'(v);
    @(negedge clk); coef_we = 1'b0;
    m_coef[a] = longint'($signed(16'(v)));
  endtask

  task automatic stream(input int n, input int amp, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      longint x;
      @(negedge clk);
      if (($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
      end else begin
        x = longint'($signed(12'($urandom % (2 * amp + 1)) - 12'(amp)));
        in_valid = 1'b1; in_sample = 12'(x);
        model_step(x);
      end
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic stream_const(input int n, input int x);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sample = 12'(x);
      model_step(longint'(x));
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_drained(input string req);
    checks++;
    if (exp_i.size() != 0) begin
      failures++;
      $display("FAIL %s: pending expected outputs actual=%0d expected=0", req, exp_i.size());
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_i.size() == 0) begin
        failures++;
        $display("FAIL R5: unexpected output actual=%0d/%0d expected=none", sx16(out_i), sx16(out_q));
      end else begin
        longint ei, eq;
        ei = exp_i.pop_front(); eq = exp_q.pop_front();
        if (sx16(out_i) != ei || sx16(out_q) != eq) begin
          failures++;
          $display("FAIL %s: output actual=%0d/%0d expected=%0d/%0d", cur_req, sx16(out_i), sx16(out_q), ei, eq);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    checks++;
    if (out_valid !== 1'b0 || out_i !== 16'd0 || out_q !== 16'd0) begin
      failures++;
      $display("FAIL R1: reset outputs actual=%b/%0h/%0h expected=0/0/0", out_valid, out_i, out_q);
    end
    @(negedge clk); rst = 1'b0;
    model_reset();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_i !== 16'd0) begin
      failures++;
      $display("FAIL R1: post-reset actual=%b/%0h expected=0/0", out_valid, out_i);
    end

    // R2 R3 R4: DC tuning, single tap, D=1
    cur_req = "R2 R3 R4";
    dec_factor = 8'd1; tune_word = 32'd0;
    write_coef(0, 32767);
    stream_const(5, -2048);
    stream_const(5, 2047);
    check_drained("R5");

    // R2 R3 R4 R5: random tuning, random taps, D=4, gapped input
    do_reset();
    cur_req = "R2 R3 R4 R5";
    dec_factor = 8'd4; tune_word = $urandom;
    for (int t = 0; t < 8; t++) write_coef(t, int'($urandom % 16384) - 8192);
    stream(400, 2047, 30);
    check_drained("R5");

    // R5: D=0 behaves like D=1
    do_reset();
    cur_req = "R5 D0";
    dec_factor = 8'd0; tune_word = 32'h0123_4567;
    for (int t = 0; t < 8; t++) write_coef(t, 4000);
    stream(60, 1500, 10);
    check_drained("R5");

    // R5 R6: D=7, coefficient rewrite mid-stream without reset
    do_reset();
    cur_req = "R6 before";
    dec_factor = 8'd7; tune_word = 32'h2000_0001;
    for (int t = 0; t < 8; t++) write_coef(t, int'($urandom % 20000) - 10000);
    stream(40, 2047, 20);
    check_drained("R6");
    cur_req = "R6 after";
    for (int t = 0; t < 8; t++) write_coef(t, int'($urandom % 20000) - 10000);
    stream(40, 2047, 20);
    check_drained("R6");

    // R7: independent rail gain and offset
    do_reset();
    cur_req = "R7";
    dec_factor = 8'd3; tune_word = $urandom;
    gain_i = 16'd2048; gain_q = 16'hF000; offset_i = 16'd1000; offset_q = 16'hFC18;
    for (int t = 0; t < 8; t++) write_coef(t, int'($urandom % 32768) - 16384);
    stream(200, 2047, 25);
    check_drained("R7");

    // R8: saturation both directions
    do_reset();
    cur_req = "R8";
    sat_seen = 0;
    dec_factor = 8'd2; tune_word = 32'h0800_0000;
    gain_i = 16'h7FFF; gain_q = 16'h7FFF; offset_i = 16'h7000; offset_q = 16'h9000;
    for (int t = 0; t < 8; t++) write_coef(t, 32767);
    stream(120, 2047, 0);
    check_drained("R8");
    checks++;
    if (sat_seen == 0) begin
      failures++;
      $display("FAIL R8: saturating outputs actual=0 expected>0");
    end

    // R9 hold between pulses: outputs unchanged while idle
    begin
      logic [15:0] hi, hq;
      hi = out_i; hq = out_q;
      repeat (10) @(negedge clk);
      checks++;
      if (out_i !== hi || out_q !== hq || out_valid !== 1'b0) begin
        failures++;
        $display("FAIL R9: hold actual=%0h/%0h expected=%0h/%0h", out_i, out_q, hi, hq);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule